// File: doc/BRIEF.md
# Page Class Key Permission Checker

This block decides whether one memory access may proceed once a hashed page table entry has been found. It takes the rights that the entry's page-protection field already grants and narrows them with a second, per-key access mask. A 5-bit class key is built from two separate fields of the entry's second doubleword. The key picks a 2-bit slice of a 64-bit authority mask register, and that slice can remove read or write permission. When the access is refused, the block reports whether the fault is on an instruction fetch. For a data access it builds a status word that separates page-protection violations from key violations.

The page table search, the segment lookup and the delivery of the exception happen around the block. It takes one access per cycle on a valid strobe. It returns its verdict one cycle later with a matching valid pulse, and it keeps that verdict on its outputs until the next access arrives.

Top module: `pkc_checker`

## Requirements
- R1: The class key is `{pte_dw1[63:62], pte_dw1[11:9]}`. Entry bits 63:62 form key bits 4:3 and entry bits 11:9 form key bits 2:0.
- R2: Key k selects mask bits `auth_mask[63-2k : 62-2k]`. Key 0 uses bits 63:62 and key 31 uses bits 1:0.
- R3: In the selected pair, the upper bit grants write and the lower bit grants read. Rights vectors are 3 bits wide: bit 2 is read, bit 1 is write and bit 0 is execute.
- R4: The key check never removes execute, so `final_rights[0]` always equals the execute bit of `pp_rights`.
- R5: When `key_en` is low, the key check grants all three rights and `final_rights` equals `pp_rights`.
- R6: `final_rights` is the bitwise AND of `pp_rights` and the key rights. Access code 0 is a load and needs read. Code 1 is a store and needs write. Code 2 is a fetch and needs execute. Code 3 is handled as a load. `fault` is high when the needed right is missing from `final_rights`.
- R7: A refused fetch raises `ifetch_fault` and sets `ifault_code` to 0x08000000, and `dstatus` stays 0. Both `ifetch_fault` and `ifault_code` are 0 for every other result.
- R8: A refused data access builds `dstatus` from zero as follows. Bit 27 (0x08000000) is set if `pp_rights` lacks the needed right. Bit 25 (0x02000000) is set if the access is a store. Bit 21 (0x00200000) is set if the key rights lack the needed right. `dstatus` is 0 when no data fault occurs.
- R9: Results appear on the clock edge after the one that samples `in_valid`, together with a one-cycle `out_valid` pulse. All result outputs hold their values through cycles without `in_valid`. Reset clears every output to 0.
- R10: A store refused by both checks at once reports 0x0A200000, with both violation bits set together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An access is presented this cycle |
| pte_dw1 | input | 64 | Second doubleword of the page table entry |
| auth_mask | input | 64 | Authority mask register |
| pp_rights | input | 3 | Page-protection rights {read, write, execute} |
| acc_type | input | 2 | 0 load, 1 store, 2 fetch, 3 treated as load |
| key_en | input | 1 | Enables key checking |
| out_valid | output | 1 | Result pulse, one cycle after in_valid |
| final_rights | output | 3 | Combined rights {read, write, execute} |
| fault | output | 1 | The access is refused |
| ifetch_fault | output | 1 | The refused access is a fetch |
| ifault_code | output | 32 | Instruction fault code, 0x08000000 on a refused fetch |
| dstatus | output | 32 | Data fault status word |

## Verification
Directed entries place the key's upper bits alone and its lower bits alone, so a swapped or misaligned key field selects the wrong mask pair. Keys 0 and 31 check both ends of the mask. Single-bit mask pairs tell the read bit apart from the write bit. Other cases separate the two fault sources from each other: a refusal by page protection only, a refusal by key only, and one store refused by both checks. A fetch with and without execute rights shows that the key never removes execute. A run with the strap low and an all-zero mask shows that the key check is bypassed. Idle cycles with changing inputs show that the outputs hold, and a long random stream is compared against the bench model on every cycle.

// File: rtl/pkc_pkg.sv
package pkc_pkg;

    localparam int PTE_W    = 64;
    localparam int MASK_W   = 64;
    localparam int KEY_W    = 5;
    localparam int STAT_W   = 32;
    localparam int KEY_HI_W = 2;
    localparam int KEY_LO_W = KEY_W - KEY_HI_W;
    localparam int KEY_HI_POS = 62;
    localparam int KEY_LO_POS = 9;

    localparam int ST_PP_BIT    = 27;
    localparam int ST_STORE_BIT = 25;
    localparam int ST_KEY_BIT   = 21;
    localparam logic [STAT_W-1:0] IFETCH_CODE = 32'h0800_0000;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } rights_t;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_ALT   = 2'd3
    } acc_e;

    typedef struct packed {
        rights_t           rights;
        logic              fault;
        logic              ifault;
        logic [STAT_W-1:0] icode;
        logic [STAT_W-1:0] status;
    } verdict_t;

    localparam rights_t RIGHTS_ALL = '{rd: 1'b1, wr: 1'b1, ex: 1'b1};

    function automatic rights_t need_of(input acc_e acc);
        rights_t n;
        n = '0;
        case (acc)
            ACC_STORE: n.wr = 1'b1;
            ACC_FETCH: n.ex = 1'b1;
            default:   n.rd = 1'b1;
        endcase
        return n;
    endfunction

    function automatic logic lacks(input rights_t have, input rights_t need);
        return |(need & ~have);
    endfunction

endpackage

// File: rtl/pkc_key_extract.sv
module pkc_key_extract
    import pkc_pkg::*;
#(
    parameter int W      = PTE_W,
    parameter int HI_POS = KEY_HI_POS,
    parameter int LO_POS = KEY_LO_POS
) (
    input  logic [W-1:0]     entry,
    output logic [KEY_W-1:0] key
);
    logic [KEY_HI_W-1:0] hi_part;
    logic [KEY_LO_W-1:0] lo_part;
    logic                unused_entry;

    assign hi_part      = entry[HI_POS +: KEY_HI_W];
    assign lo_part      = entry[LO_POS +: KEY_LO_W];
    assign key          = {hi_part, lo_part};
    assign unused_entry = ^entry;
endmodule

// File: rtl/pkc_mask_select.sv
module pkc_mask_select
    import pkc_pkg::*;
#(
    parameter int MW = MASK_W,
    parameter int KW = KEY_W
) (
    input  logic [MW-1:0] mask,
    input  logic [KW-1:0] key,
    input  logic          enable,
    output rights_t       key_rights
);
    localparam int NKEYS = MW / 2;

    logic [1:0] pairs [NKEYS];
    logic [1:0] sel;

    for (genvar g = 0; g < NKEYS; g++) begin : g_pair
        assign pairs[g] = mask[MW-1-2*g -: 2];
    end

    assign sel = pairs[key];

    always_comb begin
        if (enable) begin
            key_rights.rd = sel[0];
            key_rights.wr = sel[1];
            key_rights.ex = 1'b1;
        end else begin
            key_rights = RIGHTS_ALL;
        end
    end
endmodule

// File: rtl/pkc_verdict.sv
module pkc_verdict
    import pkc_pkg::*;
(
    input  rights_t  pp,
    input  rights_t  kr,
    input  acc_e     acc,
    output verdict_t v
);
    rights_t need;
    rights_t combined;
    logic    refused;
    logic    is_fetch;

    always_comb begin
        need     = need_of(acc);
        combined = pp & kr;
        refused  = lacks(combined, need);
        is_fetch = (acc == ACC_FETCH);

        v        = '0;
        v.rights = combined;
        v.fault  = refused;
        if (refused && is_fetch) begin
            v.ifault = 1'b1;
            v.icode  = IFETCH_CODE;
        end else if (refused) begin
            v.status[ST_PP_BIT]    = lacks(pp, need);
            v.status[ST_STORE_BIT] = (acc == ACC_STORE);
            v.status[ST_KEY_BIT]   = lacks(kr, need);
        end
    end
endmodule

// File: rtl/pkc_checker.sv
module pkc_checker
    import pkc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [PTE_W-1:0]  pte_dw1,
    input  logic [MASK_W-1:0] auth_mask,
    input  logic [2:0]        pp_rights,
    input  logic [1:0]        acc_type,
    input  logic              key_en,
    output logic              out_valid,
    output logic [2:0]        final_rights,
    output logic              fault,
    output logic              ifetch_fault,
    output logic [STAT_W-1:0] ifault_code,
    output logic [STAT_W-1:0] dstatus
);
    logic [KEY_W-1:0] key;
    rights_t          kr;
    verdict_t         vd;
    verdict_t         vd_q;

    pkc_key_extract #(.W(PTE_W)) u_key (
        .entry (pte_dw1),
        .key   (key)
    );

    pkc_mask_select #(.MW(MASK_W), .KW(KEY_W)) u_mask (
        .mask       (auth_mask),
        .key        (key),
        .enable     (key_en),
        .key_rights (kr)
    );

    pkc_verdict u_verdict (
        .pp  (rights_t'(pp_rights)),
        .kr  (kr),
        .acc (acc_e'(acc_type)),
        .v   (vd)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            vd_q      <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                vd_q <= vd;
            end
        end
    end

    assign final_rights = vd_q.rights;
    assign fault        = vd_q.fault;
    assign ifetch_fault = vd_q.ifault;
    assign ifault_code  = vd_q.icode;
    assign dstatus      = vd_q.status;

    AST_EXEC_KEPT: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> (final_rights[0] == $past(pp_rights[0]))); // R4

    AST_RIGHTS_SUBSET: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ((final_rights & ~$past(pp_rights)) == 3'b000)); // R6

    AST_FETCH_NO_STATUS: assert property (@(posedge clk) disable iff (rst)
        ifetch_fault |-> (fault && dstatus == '0 && ifault_code == IFETCH_CODE)); // R7

    AST_STORE_FLAG: assert property (@(posedge clk) disable iff (rst)
        (in_valid && acc_type == 2'd1) |=> (!fault || dstatus[ST_STORE_BIT])); // R8

    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid); // R9

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(final_rights) && $stable(fault)
                       && $stable(dstatus) && $stable(ifetch_fault))); // R9
endmodule

// File: tb/pkc_checker_test.sv
module pkc_checker_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [63:0] pte_dw1 = '0;
    logic [63:0] auth_mask = '0;
    logic [2:0]  pp_rights = '0;
    logic [1:0]  acc_type = '0;
    logic        key_en = 1'b0;
    logic        out_valid;
    logic [2:0]  final_rights;
    logic        fault;
    logic        ifetch_fault;
    logic [31:0] ifault_code;
    logic [31:0] dstatus;

    int errors = 0;
    int checks = 0;

    logic [2:0]  e_rights = '0;
    logic        e_fault = 1'b0;
    logic        e_ifault = 1'b0;
    logic [31:0] e_code = '0;
    logic [31:0] e_status = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkc_checker uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .pte_dw1(pte_dw1),
        .auth_mask(auth_mask), .pp_rights(pp_rights), .acc_type(acc_type),
        .key_en(key_en), .out_valid(out_valid), .final_rights(final_rights),
        .fault(fault), .ifetch_fault(ifetch_fault), .ifault_code(ifault_code),
        .dstatus(dstatus)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // behavioural reference, written from the requirements
    task automatic model(input logic [63:0] pte, input logic [63:0] mask,
                         input logic [2:0] pp, input logic [1:0] acc, input logic en);
        int key;
        int pair;
        int need;
        int kr;
        int fin;
        key  = int'(pte[63:62]) * 8 + int'(pte[11:9]);
        pair = int'((mask >> (2 * (31 - key))) & 64'd3);
        kr   = en ? (1 + ((pair & 1) ? 4 : 0) + ((pair & 2) ? 2 : 0)) : 7;
        need = (acc == 2'd1) ? 2 : (acc == 2'd2) ? 1 : 4;
        fin  = int'(pp) & kr;
        e_rights = fin[2:0];
        e_fault  = (fin & need) == 0;
        e_ifault = e_fault && acc == 2'd2;
        e_code   = e_ifault ? 32'h0800_0000 : 32'h0;
        e_status = 32'h0;
        if (e_fault && acc != 2'd2) begin
            if ((int'(pp) & need) == 0) e_status = e_status | 32'h0800_0000;
            if (acc == 2'd1)            e_status = e_status | 32'h0200_0000;
            if ((kr & need) == 0)       e_status = e_status | 32'h0020_0000;
        end
    endtask

    task automatic compare(input logic exp_valid);
        chk("R9 out_valid", {63'b0, out_valid}, {63'b0, exp_valid});
        chk("R6 final_rights", {61'b0, final_rights}, {61'b0, e_rights});
        chk("R6 fault", {63'b0, fault}, {63'b0, e_fault});
        chk("R7 ifetch_fault", {63'b0, ifetch_fault}, {63'b0, e_ifault});
        chk("R7 ifault_code", {32'b0, ifault_code}, {32'b0, e_code});
        chk("R8 dstatus", {32'b0, dstatus}, {32'b0, e_status});
    endtask

    task automatic step(input logic v, input logic [63:0] pte, input logic [63:0] mask,
                        input logic [2:0] pp, input logic [1:0] acc, input logic en);
        @(negedge clk);
        in_valid = v; pte_dw1 = pte; auth_mask = mask;
        pp_rights = pp; acc_type = acc; key_en = en;
        if (v) model(pte, mask, pp, acc, en);
        @(negedge clk);
        compare(v);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        compare(1'b0);                               // R9 reset state
        rst = 1'b0;

        // R1 key 16 from bit 63 alone, R2 pair at bits 31:30 = read only
        step(1, 64'h8000_0000_0000_0000, 64'h0000_0000_4000_0000, 3'b111, 2'd0, 1);
        chk("R1 key hi part load rights", {61'b0, final_rights}, 64'd5);
        step(1, 64'h8000_0000_0000_0000, 64'h0000_0000_4000_0000, 3'b111, 2'd1, 1);
        chk("R1 key hi part store status", {32'b0, dstatus}, 64'h0220_0000);
        // R1 key 4 from bit 11 alone: pair at bits 55:54
        step(1, 64'h0000_0000_0000_0800, 64'h00C0_0000_0000_0000, 3'b111, 2'd1, 1);
        chk("R1 key lo part", {63'b0, fault}, 64'd0);
        // R2 key 0 uses bits 63:62, key 31 uses bits 1:0
        step(1, 64'h0, 64'hC000_0000_0000_0000, 3'b111, 2'd0, 1);
        chk("R2 key0 rights", {61'b0, final_rights}, 64'd7);
        step(1, 64'hC000_0000_0000_0E00, 64'h0000_0000_0000_0003, 3'b111, 2'd1, 1);
        chk("R2 key31 rights", {61'b0, final_rights}, 64'd7);
        step(1, 64'hC000_0000_0000_0E00, 64'hC000_0000_0000_0000, 3'b111, 2'd0, 1);
        chk("R2 key31 wrong pair", {63'b0, fault}, 64'd1);
        // R3 pair 10 grants write only
        step(1, 64'h0, 64'h8000_0000_0000_0000, 3'b111, 2'd0, 1);
        chk("R3 write-only pair", {61'b0, final_rights}, 64'd3);
        // R4 fetch with mask zero still allowed
        step(1, 64'h0, 64'h0, 3'b001, 2'd2, 1);
        chk("R4 exec kept", {63'b0, fault}, 64'd0);
        // R7 fetch without execute
        step(1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b110, 2'd2, 1);
        chk("R7 fetch code", {32'b0, ifault_code}, 64'h0800_0000);
        chk("R7 fetch no status", {32'b0, dstatus}, 64'h0);
        // R5 strap low bypasses a zero mask
        step(1, 64'h0, 64'h0, 3'b110, 2'd1, 0);
        chk("R5 bypass rights", {61'b0, final_rights}, 64'd6);
        // R8 page-protection only on a load; code 3 as load
        step(1, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 3'b011, 2'd3, 1);
        chk("R8 pp-only load", {32'b0, dstatus}, 64'h0800_0000);
        // R10 store refused by both checks
        step(1, 64'h0, 64'h0, 3'b101, 2'd1, 1);
        chk("R10 both bits", {32'b0, dstatus}, 64'h0A20_0000);
        // R9 outputs hold while idle inputs change
        step(0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 3'b000, 2'd2, 1);
        chk("R9 hold", {32'b0, dstatus}, 64'h0A20_0000);

        for (int i = 0; i < 400; i++) begin
            logic [63:0] p;
            logic [63:0] m;
            p = {$urandom, $urandom};
            m = {$urandom, $urandom};
            step(($urandom % 4) != 0, p, m, 3'($urandom), 2'($urandom), ($urandom % 5) != 0);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule